// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the host bus of a 64K x 8 flash emulation and turns single-cycle host writes into device operations. Each write arrives as a one-clock strobe with a 16-bit address and an 8-bit data byte. The decoder follows the unlock sequences that guard every operation. When a sequence completes, it issues a one-clock start pulse for one of these operations: byte program, chip erase, page erase, boot-region lock, identification entry or identification exit. The pulse comes with the address and data of the final write.

The decoder also holds the flag that says identification mode is active, and the two flags that lock the bottom or the top 8 KB boot region. Both lock flags survive the ordinary reset and are cleared only by a separate power-on reset. While the array reports an operation in progress, the decoder ignores host writes completely. The cell array, the program and erase timing and the pin timing all live outside this block.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After power-on reset and reset, the decoder is in read mode. No start pulse is high, the identification flag is 0 and both lock flags are 0.
- R2: A byte program starts after four writes: 0xAA at 0x5555, 0x55 at 0x2AAA, 0xA0 at 0x5555, then any write. That last write's address and data appear on op_addr/op_data with prog_go.
- R3: Chip erase starts after six writes: 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x10@0x5555.
- R4: Page erase takes the same first five writes as R3, then 0x50 at any address. op_page carries address bits [15:12] of that sixth write.
- R5: Boot lock set-up takes the first five writes of R3, then 0x70@0x5555. The next write then locks a region: address 0xFFFF sets lock_top and address 0x0000 sets lock_bot, and lock_go pulses. Its data is ignored. Any other address sets no lock. A set lock stays set until power-on reset.
- R6: A program target, or a page-erase address, inside a locked region gives no start pulse. The top region is address bits [15:13] = 3'b111. The bottom region is bits [15:13] = 3'b000.
- R7: A write with the wrong address or data at any step of a sequence produces no pulse. The decoder then returns to read mode, so the writes that would have followed start nothing.
- R8: 0x90@0x5555 as the third write enters identification mode (id_enter_go, id_mode=1). Two writes leave it (id_exit_go, id_mode=0): 0xF0@0x5555 as the third write, or a single 0xF0 at any address written from read mode.
- R9: A write strobe that arrives while op_busy=1 has no effect. No pulse is issued and the position within a sequence is kept.
- R10: Every start pulse lasts exactly one clock. It is high in the cycle after the clock edge that samples the final write strobe, and at most one start pulse is high at a time.
- R11: The reset input clears the identification flag and the sequence position but leaves both lock flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of sequence and identification flag |
| por_n | input | 1 | Active-low power-on reset, also clears lock flags |
| wr_stb | input | 1 | One-clock host write strobe |
| wr_addr | input | 16 | Host write address |
| wr_data | input | 8 | Host write data |
| op_busy | input | 1 | Program or erase in progress |
| prog_go | output | 1 | Byte program start pulse |
| chip_go | output | 1 | Chip erase start pulse |
| page_go | output | 1 | Page erase start pulse |
| lock_go | output | 1 | Boot region lock pulse |
| id_enter_go | output | 1 | Identification entry pulse |
| id_exit_go | output | 1 | Identification exit pulse |
| op_addr | output | 16 | Address of the write that completed the last operation |
| op_data | output | 8 | Data of that write |
| op_page | output | 4 | Page index taken from op_addr |
| id_mode | output | 1 | Identification mode active |
| lock_top | output | 1 | Top 8 KB region locked |
| lock_bot | output | 1 | Bottom 8 KB region locked |

## Verification
The two functions that can meet in one cycle are the final write of a sequence and the busy input: a completing write can arrive in the same cycle as op_busy. The random stimulus provokes this by inserting, at a random point in a command, a busy-qualified copy of the write that comes next. This includes the final write. The bench expects no pulse from the busy copy. It then expects the unchanged sequence to finish on the real write that follows. A second meeting point is a lock setting in the cycle before a program or page erase aims at the freshly locked region; this is checked by the refusal expectations.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  localparam int DATA_W = 8;

  localparam logic [DATA_W-1:0] K_FIRST  = 8'hAA;
  localparam logic [DATA_W-1:0] K_SECOND = 8'h55;
  localparam logic [DATA_W-1:0] K_PROG   = 8'hA0;
  localparam logic [DATA_W-1:0] K_ERSET  = 8'h80;
  localparam logic [DATA_W-1:0] K_IDIN   = 8'h90;
  localparam logic [DATA_W-1:0] K_IDOUT  = 8'hF0;
  localparam logic [DATA_W-1:0] K_CHIP   = 8'h10;
  localparam logic [DATA_W-1:0] K_PAGE   = 8'h50;
  localparam logic [DATA_W-1:0] K_LOCK   = 8'h70;

  typedef enum logic [2:0] {
    SQ_READ, SQ_KEY1, SQ_KEY2, SQ_ERSET, SQ_EKEY1, SQ_EKEY2, SQ_PROG, SQ_LOCKSEL
  } seq_t;

  typedef enum logic [2:0] {
    OP_NONE, OP_PROG, OP_CHIP, OP_PAGE, OP_LOCK_TOP, OP_LOCK_BOT, OP_ID_IN, OP_ID_OUT
  } op_t;
endpackage

// File: rtl/fcd_guard.sv
module fcd_guard #(
  parameter int ADDR_W = 16,
  parameter int BOOT_W = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              lock_top,
  input  logic              lock_bot,
  output logic              blocked
);
  function automatic logic in_top_zone(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: BOOT_W] == {BOOT_W{1'b1}};
  endfunction

  function automatic logic in_bot_zone(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: BOOT_W] == {BOOT_W{1'b0}};
  endfunction

  assign blocked = (lock_top && in_top_zone(addr)) || (lock_bot && in_bot_zone(addr));
endmodule

// File: rtl/fcd_lock.sv
module fcd_lock (
  input  logic clk,
  input  logic por_n,
  input  logic set_top,
  input  logic set_bot,
  output logic lock_top,
  output logic lock_bot
);
  logic [1:0] sets;
  logic [1:0] flags;
  assign sets = {set_top, set_bot};

  for (genvar g = 0; g < 2; g++) begin : g_flag
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)       flags[g] <= 1'b0;
      else if (sets[g]) flags[g] <= 1'b1;
    end
  end

  assign lock_top = flags[1];
  assign lock_bot = flags[0];
endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] KEY_A = 16'h5555,
  parameter logic [ADDR_W-1:0] KEY_B = 16'h2AAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic              busy,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic              blocked,
  output seq_t              state,
  output op_t               op,
  output logic              refused
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] BOT_ADDR = {ADDR_W{1'b0}};

  seq_t nxt;
  logic take;
  logic first_hit;
  logic second_hit;
  logic at_key_a;

  assign take       = wr_stb && !busy;
  assign at_key_a   = (addr == KEY_A);
  assign first_hit  = at_key_a && (data == K_FIRST);
  assign second_hit = (addr == KEY_B) && (data == K_SECOND);

  always_comb begin
    nxt     = state;
    op      = OP_NONE;
    refused = 1'b0;
    if (take) begin
      nxt = SQ_READ;
      case (state)
        SQ_READ: begin
          if (first_hit)              nxt = SQ_KEY1;
          else if (data == K_IDOUT)   op  = OP_ID_OUT;
        end
        SQ_KEY1: if (second_hit) nxt = SQ_KEY2;
        SQ_KEY2: begin
          if (at_key_a) begin
            case (data)
              K_PROG:  nxt = SQ_PROG;
              K_ERSET: nxt = SQ_ERSET;
              K_IDIN:  op  = OP_ID_IN;
              K_IDOUT: op  = OP_ID_OUT;
              default: nxt = SQ_READ;
            endcase
          end
        end
        SQ_ERSET: if (first_hit)  nxt = SQ_EKEY1;
        SQ_EKEY1: if (second_hit) nxt = SQ_EKEY2;
        SQ_EKEY2: begin
          if (data == K_PAGE) begin
            if (blocked) refused = 1'b1;
            else         op      = OP_PAGE;
          end else if (at_key_a && data == K_CHIP) begin
            op = OP_CHIP;
          end else if (at_key_a && data == K_LOCK) begin
            nxt = SQ_LOCKSEL;
          end
        end
        SQ_PROG: begin
          if (blocked) refused = 1'b1;
          else         op      = OP_PROG;
        end
        SQ_LOCKSEL: begin
          if (addr == TOP_ADDR)      op = OP_LOCK_TOP;
          else if (addr == BOT_ADDR) op = OP_LOCK_BOT;
        end
        default: nxt = SQ_READ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SQ_READ;
    else        state <= nxt;
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 4,
  parameter int BOOT_W = 3,
  parameter logic [ADDR_W-1:0] KEY_A = 16'h5555,
  parameter logic [ADDR_W-1:0] KEY_B = 16'h2AAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              op_busy,
  output logic              prog_go,
  output logic              chip_go,
  output logic              page_go,
  output logic              lock_go,
  output logic              id_enter_go,
  output logic              id_exit_go,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data,
  output logic [PAGE_W-1:0] op_page,
  output logic              id_mode,
  output logic              lock_top,
  output logic              lock_bot
);
  seq_t seq_state;
  op_t  seq_op;
  logic seq_refused;
  logic guard_blocked;
  op_t  op_q;
  logic id_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  fcd_guard #(.ADDR_W(ADDR_W), .BOOT_W(BOOT_W)) u_guard (
    .addr     (wr_addr),
    .lock_top (lock_top),
    .lock_bot (lock_bot),
    .blocked  (guard_blocked)
  );

  fcd_seq #(.ADDR_W(ADDR_W), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_stb  (wr_stb),
    .busy    (op_busy),
    .addr    (wr_addr),
    .data    (wr_data),
    .blocked (guard_blocked),
    .state   (seq_state),
    .op      (seq_op),
    .refused (seq_refused)
  );

  fcd_lock u_lock (
    .clk      (clk),
    .por_n    (por_n),
    .set_top  (seq_op == OP_LOCK_TOP),
    .set_bot  (seq_op == OP_LOCK_BOT),
    .lock_top (lock_top),
    .lock_bot (lock_bot)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_NONE;
      id_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      op_q <= seq_op;
      if (seq_op != OP_NONE) begin
        addr_q <= wr_addr;
        data_q <= wr_data;
      end
      if (seq_op == OP_ID_IN)       id_q <= 1'b1;
      else if (seq_op == OP_ID_OUT) id_q <= 1'b0;
    end
  end

  assign prog_go     = (op_q == OP_PROG);
  assign chip_go     = (op_q == OP_CHIP);
  assign page_go     = (op_q == OP_PAGE);
  assign lock_go     = (op_q == OP_LOCK_TOP) || (op_q == OP_LOCK_BOT);
  assign id_enter_go = (op_q == OP_ID_IN);
  assign id_exit_go  = (op_q == OP_ID_OUT);
  assign op_addr     = addr_q;
  assign op_data     = data_q;
  assign op_page     = addr_q[ADDR_W-1 -: PAGE_W];
  assign id_mode     = id_q;
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BOOT_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              por_n,
  input logic              wr_stb,
  input logic              op_busy,
  input logic              prog_go,
  input logic              chip_go,
  input logic              page_go,
  input logic              lock_go,
  input logic              id_enter_go,
  input logic              id_exit_go,
  input logic [ADDR_W-1:0] op_addr,
  input logic              id_mode,
  input logic              lock_top,
  input logic              lock_bot,
  input seq_t              seq_state,
  input logic              seq_refused
);
  logic [5:0] pulses;
  logic       tgt_top;
  logic       tgt_bot;
  assign pulses  = {prog_go, chip_go, page_go, lock_go, id_enter_go, id_exit_go};
  assign tgt_top = op_addr[ADDR_W-1 -: BOOT_W] == {BOOT_W{1'b1}};
  assign tgt_bot = op_addr[ADDR_W-1 -: BOOT_W] == {BOOT_W{1'b0}};

  p_single_op_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pulses));
  p_prog_one_clock_r10: assert property (@(posedge clk) disable iff (!rst_n)
    prog_go |=> !prog_go);
  p_chip_one_clock_r10: assert property (@(posedge clk) disable iff (!rst_n)
    chip_go |=> !chip_go);
  p_busy_no_op_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && op_busy) |=> (pulses == 6'b0));
  p_busy_keeps_seq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && op_busy) |=> $stable(seq_state));
  p_idle_keeps_seq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(seq_state));
  p_refuse_no_op_r6: assert property (@(posedge clk) disable iff (!rst_n)
    seq_refused |=> (pulses == 6'b0));
  p_prog_not_locked_r6: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    prog_go |-> !((lock_top && tgt_top) || (lock_bot && tgt_bot)));
  p_page_not_locked_r6: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    page_go |-> !((lock_top && tgt_top) || (lock_bot && tgt_bot)));
  p_id_enter_r8: assert property (@(posedge clk) disable iff (!rst_n)
    id_enter_go |-> id_mode);
  p_id_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    id_exit_go |-> !id_mode);
  p_lock_go_flag_r5: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    lock_go |-> (lock_top || lock_bot));
  p_top_sticky_r5: assert property (@(posedge clk) disable iff (!por_n)
    lock_top |=> lock_top);
  p_bot_sticky_r5: assert property (@(posedge clk) disable iff (!por_n)
    lock_bot |=> lock_bot);
endmodule

bind flash_cmd_decoder fcd_checker #(.ADDR_W(ADDR_W), .BOOT_W(BOOT_W)) u_fcd_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .por_n       (por_n),
  .wr_stb      (wr_stb),
  .op_busy     (op_busy),
  .prog_go     (prog_go),
  .chip_go     (chip_go),
  .page_go     (page_go),
  .lock_go     (lock_go),
  .id_enter_go (id_enter_go),
  .id_exit_go  (id_exit_go),
  .op_addr     (op_addr),
  .id_mode     (id_mode),
  .lock_top    (lock_top),
  .lock_bot    (lock_bot),
  .seq_state   (seq_state),
  .seq_refused (seq_refused)
);

// File: tb/flash_cmd_decoder_test.sv
module flash_cmd_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        por_n = 1'b0;
  logic        wr_stb = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        op_busy = 1'b0;
  logic        prog_go, chip_go, page_go, lock_go, id_enter_go, id_exit_go;
  logic [15:0] op_addr;
  logic [7:0]  op_data;
  logic [3:0]  op_page;
  logic        id_mode, lock_top, lock_bot;

  always #10 clk = ~clk;

  flash_cmd_decoder uut (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .op_busy(op_busy), .prog_go(prog_go), .chip_go(chip_go),
    .page_go(page_go), .lock_go(lock_go), .id_enter_go(id_enter_go),
    .id_exit_go(id_exit_go), .op_addr(op_addr), .op_data(op_data), .op_page(op_page),
    .id_mode(id_mode), .lock_top(lock_top), .lock_bot(lock_bot)
  );

  int checks = 0;
  int errors = 0;

  // bench model: step counter of the command being received
  int m_step;
  bit m_id, m_top, m_bot;

  // pulse vector order: {prog, chip, page, lock, id_in, id_out}
  function automatic logic [5:0] seen();
    return {prog_go, chip_go, page_go, lock_go, id_enter_go, id_exit_go};
  endfunction

  function automatic bit zone_locked(input logic [15:0] a);
    return (m_top && a >= 16'hE000) || (m_bot && a < 16'h2000);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_step(input logic [15:0] a, input logic [7:0] d, input bit bz,
                            output logic [5:0] ev, output string tag);
    int s;
    ev = 6'b0;
    tag = "R7";
    if (bz) begin tag = "R9"; return; end
    s = m_step;
    m_step = 0;
    if (s == 0) begin
      if (a == 16'h5555 && d == 8'hAA) m_step = 1;
      else if (d == 8'hF0) begin ev = 6'b000001; tag = "R8"; end
    end else if (s == 1 || s == 4) begin
      if (a == 16'h2AAA && d == 8'h55) m_step = s + 1;
    end else if (s == 3) begin
      if (a == 16'h5555 && d == 8'hAA) m_step = 4;
    end else if (s == 2) begin
      if (a == 16'h5555) begin
        if (d == 8'hA0) m_step = 6;
        else if (d == 8'h80) m_step = 3;
        else if (d == 8'h90) begin ev = 6'b000010; tag = "R8"; end
        else if (d == 8'hF0) begin ev = 6'b000001; tag = "R8"; end
      end
    end else if (s == 5) begin
      if (d == 8'h50) begin
        if (zone_locked(a)) tag = "R6";
        else begin ev = 6'b001000; tag = "R4"; end
      end else if (a == 16'h5555 && d == 8'h10) begin ev = 6'b010000; tag = "R3"; end
      else if (a == 16'h5555 && d == 8'h70) m_step = 7;
    end else if (s == 6) begin
      if (zone_locked(a)) tag = "R6";
      else begin ev = 6'b100000; tag = "R2"; end
    end else if (s == 7) begin
      if (a == 16'hFFFF) begin ev = 6'b000100; tag = "R5"; m_top = 1; end
      else if (a == 16'h0000) begin ev = 6'b000100; tag = "R5"; m_bot = 1; end
    end
    if (ev[1]) m_id = 1;
    if (ev[0]) m_id = 0;
  endtask

  task automatic put(input logic [15:0] a, input logic [7:0] d, input bit bz);
    logic [5:0] ev;
    string tag;
    model_step(a, d, bz, ev, tag);
    @(negedge clk);
    wr_stb = 1'b1; wr_addr = a; wr_data = d; op_busy = bz;
    @(negedge clk);
    wr_stb = 1'b0; op_busy = 1'b0;
    check(seen() == ev, tag, "start pulses", {26'b0, seen()}, {26'b0, ev});
    if (ev != 6'b0) begin
      check(op_addr == a && op_data == d, tag, "op addr/data",
            {8'b0, op_addr, op_data}, {8'b0, a, d});
      if (ev[3]) check(op_page == a[15:12], "R4", "page index", {28'b0, op_page}, {28'b0, a[15:12]});
    end
    check(id_mode == m_id, "R8", "id flag", {31'b0, id_mode}, {31'b0, m_id});
    check({lock_top, lock_bot} == {m_top, m_bot}, "R5", "lock flags",
          {30'b0, lock_top, lock_bot}, {30'b0, m_top, m_bot});
    @(negedge clk);
    check(seen() == 6'b0, "R10", "pulse width", {26'b0, seen()}, 32'b0);
  endtask

  task automatic do_reset(input bit with_por);
    @(negedge clk);
    rst_n = 1'b0;
    if (with_por) por_n = 1'b0;
    repeat (2) @(negedge clk);
    m_step = 0; m_id = 0;
    if (with_por) begin m_top = 0; m_bot = 0; end
    check(seen() == 6'b0 && !id_mode, "R1", "reset outputs", {25'b0, id_mode, seen()}, 32'b0);
    check({lock_top, lock_bot} == {m_top, m_bot}, "R11", "locks across reset",
          {30'b0, lock_top, lock_bot}, {30'b0, m_top, m_bot});
    rst_n = 1'b1; por_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic unlock2();
    put(16'h5555, 8'hAA, 0);
    put(16'h2AAA, 8'h55, 0);
  endtask

  task automatic erase5();
    unlock2(); put(16'h5555, 8'h80, 0); unlock2();
  endtask

  // random command: builds a write list, may corrupt one step or insert a busy copy
  task automatic rand_cmd();
    logic [15:0] al[8];
    logic [7:0]  dl[8];
    int n;
    int kind;
    kind = $urandom_range(0, 15);
    al[0] = 16'h5555; dl[0] = 8'hAA; al[1] = 16'h2AAA; dl[1] = 8'h55;
    al[3] = 16'h5555; dl[3] = 8'hAA; al[4] = 16'h2AAA; dl[4] = 8'h55;
    al[2] = 16'h5555; dl[2] = 8'h80; n = 6;
    al[5] = 16'h5555;
    if (kind < 5) begin
      dl[2] = 8'hA0; al[3] = 16'($urandom); dl[3] = 8'($urandom); n = 4;
    end else if (kind < 7) begin
      dl[5] = 8'h10;
    end else if (kind < 10) begin
      al[5] = 16'($urandom); dl[5] = 8'h50;
    end else if (kind == 10) begin
      dl[5] = 8'h70; n = 7;
      al[6] = ($urandom_range(0, 2) == 0) ? 16'hFFFF :
              ($urandom_range(0, 1) == 0) ? 16'h0000 : 16'($urandom);
      dl[6] = 8'($urandom);
    end else if (kind == 11) begin
      dl[2] = 8'h90; n = 3;
    end else if (kind == 12) begin
      dl[2] = 8'hF0; n = 3;
    end else if (kind == 13) begin
      al[0] = 16'($urandom); dl[0] = 8'hF0; n = 1;
    end else begin
      n = $urandom_range(1, 3);
      for (int i = 0; i < n; i++) begin al[i] = 16'($urandom); dl[i] = 8'($urandom); end
    end
    if ($urandom_range(0, 4) == 0) begin
      int k;
      k = $urandom_range(0, n - 1);
      if ($urandom_range(0, 1) == 0) dl[k] = dl[k] ^ 8'(1 << $urandom_range(0, 7));
      else al[k] = al[k] ^ 16'(1 << $urandom_range(0, 15));
    end
    for (int i = 0; i < n; i++) begin
      if ($urandom_range(0, 7) == 0) put(al[i], dl[i], 1);
      put(al[i], dl[i], 0);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    m_step = 0; m_id = 0; m_top = 0; m_bot = 0;
    repeat (3) @(negedge clk);
    do_reset(1);

    // R8: identification entry, then one-write exit from read mode
    unlock2(); put(16'h5555, 8'h90, 0);
    put(16'h0123, 8'hF0, 0);
    unlock2(); put(16'h5555, 8'h90, 0);
    unlock2(); put(16'h5555, 8'hF0, 0);
    // R2: program a byte
    unlock2(); put(16'h5555, 8'hA0, 0); put(16'h1234, 8'h3C, 0);
    // R3: chip erase
    erase5(); put(16'h5555, 8'h10, 0);
    // R5: lock bottom, data ignored
    erase5(); put(16'h5555, 8'h70, 0); put(16'h0000, 8'h5A, 0);
    // R6: refused program and page erase into bottom region, accepted just above
    unlock2(); put(16'h5555, 8'hA0, 0); put(16'h1FFF, 8'h00, 0);
    unlock2(); put(16'h5555, 8'hA0, 0); put(16'h2000, 8'h11, 0);
    erase5(); put(16'h1000, 8'h50, 0);
    erase5(); put(16'hE000, 8'h50, 0);
    // R11: reset keeps lock, clears id
    unlock2(); put(16'h5555, 8'h90, 0);
    do_reset(0);
    // R7: wrong second write, following writes start nothing
    put(16'h5555, 8'hAA, 0); put(16'h2AAB, 8'h55, 0); put(16'h5555, 8'hA0, 0); put(16'h4000, 8'h01, 0);
    // R5: lock set-up with wrong address sets nothing
    erase5(); put(16'h5555, 8'h70, 0); put(16'h8000, 8'h00, 0);
    // R9: busy on final program write, then the real write completes
    unlock2(); put(16'h5555, 8'hA0, 0); put(16'h7777, 8'h42, 1); put(16'h7777, 8'h42, 0);
    // R5/R6: lock top, then program to top refused
    erase5(); put(16'h5555, 8'h70, 0); put(16'hFFFF, 8'h00, 0);
    unlock2(); put(16'h5555, 8'hA0, 0); put(16'hFFFF, 8'h00, 0);
    do_reset(1);

    for (int c = 0; c < 400; c++) begin
      if (c % 50 == 49) do_reset($urandom_range(0, 1) == 1);
      rand_cmd();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule